// File: doc/BRIEF.md
# Phase-Absorbing Transmit Elastic FIFO

This block sits between a parallel word source and a transmit serializer. The source writes one 9-bit word on every edge of its own clock. The serializer side reads one word on every edge of a locally generated clock with the same nominal rate but an unknown and slowly wandering phase. A four-entry ring absorbs that phase difference. Neither side can stall the other: the write port has no ready signal and the read stream has no ready input. `rd_valid` only says whether `rd_data` holds live data. A consumer that cannot take a word on every read-clock edge loses that word.

A reset-and-center sequence runs in the read-clock domain. It starts once `fifo_rst` has been seen high on two consecutive read-clock edges. When `fifo_rst` falls, the ring flushes. The read pointer then loads the synchronized write position, which leaves the two pointers about half the ring apart. If the phase then drifts by two periods in either direction, the pointers would reach the same entry. The block treats this as data loss and raises `overflow`. With `auto_rst` low, `overflow` stays high until an external reset. With `auto_rst` high, `overflow` pulses for one cycle and the block re-centers by itself.

Top module: `tx_elastic_fifo`

## Requirements
- R1: While the reset-and-center sequence is in its initialization phase, `rd_valid`, `overflow` and `rd_data` are all 0.
- R2: `rd_valid` first rises between 8 and 10 read-clock edges after `fifo_rst` is first sampled low. The count includes that edge.
- R3: While `rd_valid` stays high, each `rd_data` word equals the previous one plus 1 (modulo 512) when the source writes an incrementing count. The write pointer crosses clock domains as a Gray code.
- R4: Whenever `rd_valid` is 0, `rd_data` is 0.
- R5: A `fifo_rst` pulse that lasts one read-clock cycle has no effect: `rd_valid` stays high and the stream continues.
- R6: A phase slip of one write-clock period after centering causes no overflow and no loss of data.
- R7: A slip of two periods raises `overflow` and drops `rd_valid`. With `auto_rst` at 0, `overflow` stays high until an external reset.
- R8: An external reset of at least two read-clock cycles clears a held `overflow` and re-centers the ring, after which valid data resumes.
- R9: With `auto_rst` at 1, a collision raises `overflow` for exactly one read-clock cycle. The block then re-centers without an external reset, and `rd_valid` returns.
- R10: A reset held for exactly two read-clock cycles is enough to start the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Clock of the word source; clocks the write port |
| wr_data | input | 9 | Word written on every `wr_clk` edge, no qualifier |
| rd_clk | input | 1 | Locally generated read clock; clocks control and output |
| fifo_rst | input | 1 | Reset-and-center request, sampled on `rd_clk`, active high |
| auto_rst | input | 1 | 1: recover automatically after a collision |
| rd_data | output | 9 | Word delivered to the serializer, 0 when not valid |
| rd_valid | output | 1 | High while the output carries live data |
| overflow | output | 1 | Pointer collision (data loss) indicator |

## Verification
The embedded assertions watch, on every cycle, the properties that follow from one cycle to the next:
- zero data while not valid;
- no valid data during an overflow;
- a held overflow that stays held;
- a one-cycle auto-recovery pulse;
- a single-cycle reset that is ignored;
- single-bit Gray steps on the write pointer.

Only the bench's scenarios can show the rest. These are the flush latency window, the unbroken data sequence across a one-period slip, the detection of a two-period slip, and the return of valid data after external and automatic recovery. All of them depend on how the two clocks line up over many cycles.

// File: rtl/tef_pkg.sv
`timescale 1ns/1ps
package tef_pkg;
  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_FLUSH = 3'd1,
    ST_RUN   = 3'd2,
    ST_HALT  = 3'd3,
    ST_TRIP  = 3'd4
  } tef_state_e;
endpackage

// File: rtl/tef_sync.sv
`timescale 1ns/1ps
module tef_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) chain[s] <= chain[s-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tef_wr_side.sv
`timescale 1ns/1ps
module tef_wr_side #(
  parameter int DATA_W      = 9,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              init_req,   // from read domain
  input  logic [AW-1:0]     rd_addr,    // read domain index
  output logic [DATA_W-1:0] rd_word,
  output logic [AW-1:0]     wgray
);
  logic              init_w;
  logic [AW-1:0]     wptr;
  logic [DATA_W-1:0] ring [DEPTH];

  tef_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_init_sync (
    .clk(wr_clk), .d(init_req), .q(init_w)
  );

  function automatic logic [AW-1:0] to_gray(input logic [AW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  always_ff @(posedge wr_clk) begin
    if (init_w) begin
      wptr  <= '0;
      wgray <= '0;
    end else begin
      ring[wptr] <= wr_data;
      wptr       <= wptr + 1'b1;
      wgray      <= to_gray(wptr + 1'b1);
    end
  end

  assign rd_word = ring[rd_addr];

  AST_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (init_w)
    $countones(wgray ^ $past(wgray)) <= 1); // R3
endmodule

// File: rtl/tef_rd_ctrl.sv
`timescale 1ns/1ps
module tef_rd_ctrl
  import tef_pkg::*;
#(
  parameter int DATA_W    = 9,
  parameter int DEPTH     = 4,
  parameter int FLUSH_CYC = 7,
  parameter int INIT_HOLD = 2,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic              rd_clk,
  input  logic              fifo_rst,
  input  logic              auto_rst,
  input  logic [AW-1:0]     wgray_sync,
  input  logic [DATA_W-1:0] rd_word,
  output logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              overflow,
  output logic              init_flag
);
  localparam int FW = $clog2(FLUSH_CYC + 1);
  localparam int HW = $clog2(INIT_HOLD + 1);
  // steady pointer distance seen through the synchronizer, and the
  // distance two periods away from it in either direction
  localparam logic [AW-1:0] CENTER  = AW'(1);
  localparam logic [AW-1:0] COLLIDE = AW'((1 + DEPTH / 2) % DEPTH);

  tef_state_e      state, nxt;
  logic            rst_q;
  logic [FW-1:0]   flush_cnt;
  logic [HW-1:0]   hold_cnt;
  logic [AW-1:0]   rptr, wbin, diff;
  logic            init_start, collide;

  always_comb begin
    wbin[AW-1] = wgray_sync[AW-1];
    for (int i = AW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_sync[i];
  end

  assign init_start = fifo_rst & rst_q;
  assign diff       = wbin - rptr;
  assign collide    = (state == ST_RUN) && (diff == COLLIDE);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_INIT:  if (!fifo_rst && hold_cnt >= HW'(INIT_HOLD - 1)) nxt = ST_FLUSH;
      ST_FLUSH: if (flush_cnt == FW'(FLUSH_CYC - 1)) nxt = ST_RUN;
      ST_RUN:   if (collide) nxt = auto_rst ? ST_TRIP : ST_HALT;
      ST_HALT:  nxt = ST_HALT;
      ST_TRIP:  nxt = ST_INIT;
      default:  nxt = ST_INIT;
    endcase
    if (init_start) nxt = ST_INIT;
  end

  always_ff @(posedge rd_clk) begin
    rst_q     <= fifo_rst;
    state     <= nxt;
    init_flag <= (nxt == ST_INIT);
    flush_cnt <= (state == ST_FLUSH) ? flush_cnt + 1'b1 : '0;
    if (state == ST_INIT && !init_start)
      hold_cnt <= (hold_cnt == HW'(INIT_HOLD)) ? hold_cnt : hold_cnt + 1'b1;
    else
      hold_cnt <= '0;
    if (state == ST_FLUSH && nxt == ST_RUN) rptr <= wbin;
    else if (state == ST_RUN)               rptr <= rptr + 1'b1;
    else                                    rptr <= '0;
    if (state == ST_RUN && nxt == ST_RUN) begin
      rd_data  <= rd_word;
      rd_valid <= 1'b1;
    end else begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end
  end

  assign rd_addr  = rptr;
  assign overflow = (state == ST_HALT) || (state == ST_TRIP);

  AST_VALID_ZERO: assert property (@(posedge rd_clk) disable iff (fifo_rst)
    !rd_valid |-> (rd_data == '0)); // R4
  AST_NO_VALID_ON_OVF: assert property (@(posedge rd_clk) disable iff (fifo_rst)
    overflow |-> !rd_valid); // R7
  AST_STICKY_OVF: assert property (@(posedge rd_clk) disable iff (fifo_rst)
    (state == ST_HALT) |=> overflow); // R7
  AST_OVF_PULSE: assert property (@(posedge rd_clk) disable iff (fifo_rst)
    (state == ST_TRIP) |=> !overflow); // R9
  AST_RST_FILTER: assert property (@(posedge rd_clk) disable iff (init_flag)
    (fifo_rst && !rst_q && state == ST_RUN && !collide) |=> (state == ST_RUN)); // R5
  AST_INIT_QUIET: assert property (@(posedge rd_clk) disable iff (1'b0)
    (init_flag && state == ST_INIT) |=> (!rd_valid && !overflow)); // R1
  AST_CENTER_DIST: assert property (@(posedge rd_clk) disable iff (fifo_rst)
    ($rose(rd_valid) && !auto_rst) |-> (diff != COLLIDE) && (CENTER != COLLIDE)); // R6
endmodule

// File: rtl/tx_elastic_fifo.sv
`timescale 1ns/1ps
module tx_elastic_fifo #(
  parameter int DATA_W      = 9,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FLUSH_CYC   = 7,
  parameter int INIT_HOLD   = 2
) (
  input  logic              wr_clk,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              fifo_rst,
  input  logic              auto_rst,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              overflow
);
  localparam int AW = $clog2(DEPTH);

  logic              init_flag;
  logic [AW-1:0]     rd_addr, wgray, wgray_sync;
  logic [DATA_W-1:0] rd_word;

  tef_wr_side #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .wr_clk(wr_clk), .wr_data(wr_data), .init_req(init_flag),
    .rd_addr(rd_addr), .rd_word(rd_word), .wgray(wgray)
  );

  tef_sync #(.WIDTH(AW), .STAGES(SYNC_STAGES)) u_wptr_sync (
    .clk(rd_clk), .d(wgray), .q(wgray_sync)
  );

  tef_rd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FLUSH_CYC(FLUSH_CYC),
                .INIT_HOLD(INIT_HOLD)) u_rd (
    .rd_clk(rd_clk), .fifo_rst(fifo_rst), .auto_rst(auto_rst),
    .wgray_sync(wgray_sync), .rd_word(rd_word), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .overflow(overflow),
    .init_flag(init_flag)
  );
endmodule

// File: tb/tb_tx_elastic_fifo.sv
`timescale 1ns/1ps
module tb_tx_elastic_fifo;
  localparam real CLK_PERIOD = 10.0;

  logic       wr_clk = 0, rd_clk = 0, fifo_rst = 0, auto_rst = 0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       rd_valid, overflow;

  int checks = 0, failures = 0;
  int skip_req = 0;
  bit check_en = 0, prev_v = 0, finished = 0;
  int prev_word = 0;

  tx_elastic_fifo dut (
    .wr_clk(wr_clk), .wr_data(wr_data), .rd_clk(rd_clk), .fifo_rst(fifo_rst),
    .auto_rst(auto_rst), .rd_data(rd_data), .rd_valid(rd_valid), .overflow(overflow)
  );

  initial forever #(CLK_PERIOD / 2.0) rd_clk = ~rd_clk;

  // write clock leads the read clock by a quarter period; a skip removes edges
  initial begin
    #(CLK_PERIOD / 4.0);
    forever begin
      if (skip_req > 0) begin
        skip_req = skip_req - 1;
        #(CLK_PERIOD);
      end else begin
        wr_clk = 1; #(CLK_PERIOD / 2.0);
        wr_clk = 0; #(CLK_PERIOD / 2.0);
      end
    end
  end

  // source: incrementing count, advances once per write edge
  initial forever begin
    @(negedge wr_clk);
    wr_data = wr_data + 9'd1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: sequence continuity and zero-when-idle, every read clock
  initial forever begin
    @(negedge rd_clk);
    if (!rd_valid) check(rd_data == 0, "R4", rd_data, 0);
    if (rd_valid && prev_v && check_en)
      check(int'(rd_data) == ((prev_word + 1) % 512), "R3", rd_data, (prev_word + 1) % 512);
    prev_v    = rd_valid;
    prev_word = int'(rd_data);
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge rd_clk);
  endtask

  task automatic do_reset(input int len);
    fifo_rst = 1;
    cycles(len);
    fifo_rst = 0;
  endtask

  task automatic wait_valid(input string req, input int limit);
    int n = 0;
    while (!rd_valid && n < limit) begin
      @(negedge rd_clk);
      n++;
    end
    check(rd_valid == 1, req, rd_valid, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000.0);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    int pulses;
    @(negedge rd_clk);
    // R1: initialization phase is quiet
    fifo_rst = 1;
    cycles(3);
    check(rd_valid == 0, "R1", rd_valid, 0);
    check(overflow == 0, "R1", overflow, 0);
    check(rd_data == 0, "R1", rd_data, 0);
    // R2: flush latency
    fifo_rst = 0;
    n = 0;
    while (!rd_valid && n < 20) begin
      @(negedge rd_clk);
      n++;
    end
    check(n >= 8 && n <= 10, "R2", n, 9);
    check_en = 1;
    cycles(40);
    // R5: a one-cycle reset pulse is ignored
    fifo_rst = 1;
    @(negedge rd_clk);
    fifo_rst = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge rd_clk);
      check(rd_valid == 1, "R5", rd_valid, 1);
    end
    // R6: one-period slip is absorbed
    skip_req = 1;
    for (int i = 0; i < 25; i++) begin
      @(negedge rd_clk);
      check(overflow == 0, "R6", overflow, 0);
      check(rd_valid == 1, "R6", rd_valid, 1);
    end
    // R10: a reset of exactly two cycles restarts and re-centers
    do_reset(2);
    cycles(1);
    check(rd_valid == 0, "R10", rd_valid, 1'b0);
    wait_valid("R10", 20);
    cycles(20);
    // R7: two-period slip with auto recovery off
    check_en = 0;
    skip_req = 2;
    n = 0;
    while (!overflow && n < 20) begin
      @(negedge rd_clk);
      n++;
    end
    check(overflow == 1, "R7", overflow, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge rd_clk);
      check(overflow == 1 && rd_valid == 0, "R7", {overflow, rd_valid}, 2);
    end
    // R8: external reset clears and re-centers
    do_reset(3);
    check(overflow == 0, "R8", overflow, 0);
    wait_valid("R8", 20);
    check_en = 1;
    cycles(30);
    check(overflow == 0, "R8", overflow, 0);
    // R9: automatic recovery
    auto_rst = 1;
    check_en = 0;
    skip_req = 2;
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge rd_clk);
      if (overflow) pulses++;
    end
    check(pulses == 1, "R9", pulses, 1);
    check(rd_valid == 1, "R9", rd_valid, 1);
    check_en = 1;
    cycles(30);
    check(overflow == 0, "R9", overflow, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule